// File: doc/BRIEF.md
# Multi-Output SPI Chip-Select Controller

This block drives up to four active-low chip-select lines for one SPI host port. Software programs a single control word through a simple register port. The word holds three fields: a mode bit that chooses between software-driven and engine-driven select levels, a level bit, and a 2-bit field that names the target output. In software mode the level bit sets the chosen line directly. In hardware mode the chosen line copies the SPI engine's active-low frame signal. Lines that are not chosen stay high.

The target field reaches the output steering through a two-stage register pipeline clocked by the serial clock. The level bit bypasses that pipeline. Software that retargets the select must therefore write the new target while the level is inactive, wait two cycles, and only then write the active level. If the target and an active level go in one write, the old target is pulled low for two cycles, and the block keeps that behaviour on purpose so that drivers see the real hazard.

Top module: `cs_fanout_ctrl`

## Requirements
- R1: While reset is held and after it is released, the read port shows 0x00000002 (target 0, level 1, mode 0). With the frame input high, every chip-select output is high.
- R2: Only bit 0 (mode: 1 = software level, 0 = engine frame), bit 1 (level) and bits 9:8 (target index) are stored. Every other bit reads as zero, whatever was written.
- R3: A write strobe that is high at a clock edge stores the masked write data, and the read port shows it after that edge. Without a strobe the read value does not change.
- R4: In software mode the targeted output equals the level bit (1 = high/inactive, 0 = low/active) from the first edge after the write, with no pipeline delay.
- R5: A new target index starts steering the outputs after the second clock edge that follows the write edge. Up to then the previous target stays in use.
- R6: Every output that is not the current target is held high, so at most one output is low at any time.
- R7: In engine mode the targeted output follows the frame input in the same cycle, without a clock edge.
- R8: A single write that changes the target and sets the level low drives the old target low for two cycles, and after that the new target goes low.
- R9: Writing the new target with the level high, waiting two cycles and then writing the level low causes no low pulse on any output other than the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial (ssp) clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Stored control word; unused bits read zero |
| frame_n | input | 1 | Active-low frame signal from the SPI engine |
| cs_n | output | NUM_CS | Active-low chip-select outputs |

## Verification
Random control words written at random intervals, with a random frame level, test the masked storage and the level routing in both modes. Because the target changes often, they also show whether the pipeline delay is exactly two cycles and not one or three. Two directed sequences are run from the same starting state: a combined retarget-and-assert write and a select-first write. Side by side, they show that the two-cycle glitch on the old line is present in the first case and absent in the second. An all-ones write and an alternating-pattern write expose any reserved bit that is stored by mistake. A frame toggle with no clock edge between set and check shows whether the engine path is combinational.

// File: rtl/cs_sel_pkg.sv
package cs_sel_pkg;
  localparam int CTL_W    = 32;
  localparam int MODE_BIT = 0;
  localparam int LVL_BIT  = 1;
  localparam int TGT_LSB  = 8;
  localparam int TGT_W    = 2;
  localparam int MAX_CS   = 1 << TGT_W;

  localparam logic [CTL_W-1:0] CTL_MASK  = 32'h0000_0303;
  localparam logic [CTL_W-1:0] CTL_RESET = 32'h0000_0002;

  typedef struct packed {
    logic             sw_mode;
    logic             level;
    logic [TGT_W-1:0] target;
  } ctl_fields_t;

  function automatic logic [CTL_W-1:0] ctl_keep(input logic [CTL_W-1:0] w);
    return w & CTL_MASK;
  endfunction

  function automatic ctl_fields_t ctl_split(input logic [CTL_W-1:0] w);
    ctl_fields_t f;
    f.sw_mode = w[MODE_BIT];
    f.level   = w[LVL_BIT];
    f.target  = w[TGT_LSB +: TGT_W];
    return f;
  endfunction

  function automatic logic pick_level(input logic sw_mode, input logic level,
                                      input logic frame_n);
    return sw_mode ? level : frame_n;
  endfunction
endpackage

// File: rtl/cs_ctl_reg.sv
module cs_ctl_reg
  import cs_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl_word,
  output ctl_fields_t      ctl_f
);
  logic [CTL_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= CTL_RESET;
    else if (wr_en) word_q <= ctl_keep(wr_data);
  end

  assign ctl_word = word_q;
  assign ctl_f    = ctl_split(word_q);
endmodule

// File: rtl/cs_sel_pipe.sv
module cs_sel_pipe #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cs_out_mux.sv
module cs_out_mux #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              level,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n[i] = (sel == SEL_W'(i)) ? level : 1'b1;
  end
endmodule

// File: rtl/cs_fanout_ctrl.sv
module cs_fanout_ctrl
  import cs_sel_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              frame_n,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int SEL_W = TGT_W;

  ctl_fields_t      ctl_f;
  logic [CTL_W-1:0] ctl_word;
  logic [SEL_W-1:0] sel_eff;
  logic             drive_level;
  logic             sel_pending;

  cs_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctl_word (ctl_word),
    .ctl_f    (ctl_f)
  );

  cs_sel_pipe #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ctl_f.target),
    .dout  (sel_eff)
  );

  assign drive_level = pick_level(ctl_f.sw_mode, ctl_f.level, frame_n);
  assign sel_pending = (sel_eff != ctl_f.target);

  cs_out_mux #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_mux (
    .sel   (sel_eff),
    .level (drive_level),
    .cs_n  (cs_n)
  );

  assign rd_data = ctl_word;
endmodule

// File: rtl/cs_fanout_ctrl_chk.sv
module cs_fanout_ctrl_chk
  import cs_sel_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              frame_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic [TGT_W-1:0]  sel_eff,
  input logic              sel_pending
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         warm <= '0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~CTL_MASK) == '0);

  assert_write_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & CTL_MASK));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  assert_sw_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[MODE_BIT] |-> cs_n[sel_eff] == rd_data[LVL_BIT]);

  assert_sel_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2) |-> sel_eff == $past(rd_data[TGT_LSB +: TGT_W], 2));

  assert_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2 && $past(!wr_en) && $past(!wr_en, 2)) |-> !sel_pending);

  assert_one_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_hw_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[MODE_BIT] |-> cs_n[sel_eff] == frame_n);
endmodule

bind cs_fanout_ctrl cs_fanout_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .frame_n     (frame_n),
  .cs_n        (cs_n),
  .sel_eff     (sel_eff),
  .sel_pending (sel_pending)
);

// File: tb/sim_cs_fanout_ctrl.sv
`timescale 1ns/1ps
module sim_cs_fanout_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        frame_n = 1'b1;
  logic [3:0]  cs_n;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_word = 32'h2;
  logic [1:0]  m_d1 = 2'd0;
  logic [1:0]  m_d2 = 2'd0;

  always #2.5 clk = ~clk;

  cs_fanout_ctrl u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .frame_n (frame_n),
    .cs_n    (cs_n)
  );

  function automatic logic [3:0] exp_cs(input logic [1:0] sel, input logic sw,
                                        input logic lvl, input logic fr);
    logic [3:0] r;
    r = 4'hF;
    r[sel] = sw ? lvl : fr;
    return r;
  endfunction

  function automatic logic [3:0] model_cs();
    return exp_cs(m_d2, m_word[0], m_word[1], frame_n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic        w;
    logic [31:0] d;
    w = wr_en;
    d = wr_data;
    @(posedge clk);
    m_d2 = m_d1;
    m_d1 = m_word[9:8];
    if (w) m_word = d & 32'h0000_0303;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] word);
    wr_en = 1'b1;
    wr_data = word;
    tick();
    wr_en = 1'b0;
    wr_data = $urandom;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c5a1));
    repeat (3) @(negedge clk);
    chk("R1 reset rd", rd_data, 32'h2);
    chk("R1 reset cs", {28'd0, cs_n}, 32'hF);
    rst_n = 1'b1;
    tick();
    chk("R1 after release rd", rd_data, 32'h2);
    chk("R1 after release cs", {28'd0, cs_n}, 32'hF);

    wr(32'hFFFF_FFFF);
    chk("R2 all-ones masked", rd_data, 32'h303);
    wr(32'h0000_FCFC);
    chk("R2 alternating masked", rd_data, 32'h0);
    tick(); tick();
    frame_n = 1'b0;
    #0.5;
    chk("R7 frame low no edge", {28'd0, cs_n}, 32'hE);
    frame_n = 1'b1;
    #0.5;
    chk("R7 frame high no edge", {28'd0, cs_n}, 32'hF);

    // Combined retarget + assert: glitch on old line 0
    wr(32'h003);
    tick(); tick();
    chk("R4 level high", {28'd0, cs_n}, 32'hF);
    wr(32'h201);
    chk("R8 glitch cycle 1", {28'd0, cs_n}, 32'hE);
    tick();
    chk("R8 glitch cycle 2", {28'd0, cs_n}, 32'hE);
    tick();
    chk("R5 new target after two edges", {28'd0, cs_n}, 32'hB);

    // Select-first sequence to line 3
    wr(32'h303);
    chk("R9 no pulse 1", {28'd0, cs_n}, 32'hF);
    tick();
    chk("R9 no pulse 2", {28'd0, cs_n}, 32'hF);
    tick();
    chk("R9 no pulse 3", {28'd0, cs_n}, 32'hF);
    wr(32'h301);
    chk("R9 R4 target asserted", {28'd0, cs_n}, 32'h7);
    tick();
    chk("R3 hold without strobe", rd_data, 32'h301);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      wr_en   = (($urandom % 3) == 0);
      wr_data = $urandom;
      frame_n = $urandom % 2;
      tick();
      wr_en = 1'b0;
      chk("R2 R3 random rd", rd_data, m_word);
      chk("R4 R5 R6 R7 random cs", {28'd0, cs_n}, {28'd0, model_cs()});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule